// File: doc/BRIEF.md
# GPIB Device-Side Mode Arbiter

This block sits beside the interface logic of an IEEE 488.1 instrument and decides which single task the device should service next: a device clear, a serial poll response, talking or listening. It takes synchronous status flags from the bus interface and turns them into a registered one-hot mode. The mode comes from the IEEE 488.1 talker and listener state flags, not from the raw address flags.

The addressed-as-talker flag alone cannot select talking, because that flag is true while the device is only addressed (TADS) and also while it is being serial polled (SPAS). The arbiter therefore qualifies it with the ATN level and with a pending status-byte request. Talk mode is issued only in genuine TACS. A second output, the data-out interrupt enable, is masked when talk mode is entered, so that a level-style data-out request does not interrupt over and over. The enable is armed again once ATN is asserted or IFC is seen.

Internal states: IDLE, DCLR, SPOLL, TALK, LISTEN. Every state can reach every other. The next state is chosen each cycle by a fixed priority: IFC forces IDLE, then a live device clear gives DCLR, then a live status-byte request gives SPOLL, then qualified talker gives TALK, then addressed listener with the talker idle gives LISTEN, and otherwise IDLE. Named transitions: TALK to IDLE on ATN assertion (the TACS to TADS move), SPOLL to TALK or IDLE on the status-byte write, DCLR to the next task on acknowledge, and any state to IDLE on IFC.

Top module: `gpib_dev_arbiter`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) sets the mode to IDLE and the data-out interrupt enable to 1, and clears the pending device-clear and status-byte-served flags.
- R2: mode_o is one-hot with bit 0 IDLE, bit 1 DCLR, bit 2 SPOLL, bit 3 TALK, bit 4 LISTEN. It is registered and shows the decision made from the inputs sampled at the previous clock edge.
- R3: TALK is selected only when tad_i is 1, atn_n_i is 1 (ATN not asserted) and no live status-byte request exists. When tad_i is 1 and atn_n_i is 0 (TADS), the mode is not TALK.
- R4: With atn_n_i at 0, the block leaves TALK at the next edge. An ifc_i pulse forces mode IDLE at the next edge, whatever the other inputs are.
- R5: stb_req_i at 1 is a live status-byte request (SPOLL) until stb_wr_i is seen. From the cycle of that write on, the request stays inactive until stb_req_i returns to 0.
- R6: LISTEN is selected when lad_i is 1 and tad_i is 0, and no higher-priority task holds.
- R7: An end_rx_i pulse has no effect on the mode or the interrupt enable. In particular, listening continues through it.
- R8: When several tasks hold at once, they are ranked in this order: device clear, then serial poll, then talk, then listen.
- R9: A dcl_i pulse keeps DCLR live until dcl_ack_i is seen. A dcl_ack_i and a new dcl_i in the same cycle keep it live.
- R10: do_ie_o falls to 0 in the same cycle that mode_o becomes TALK. It returns to 1 one edge after atn_n_i is 0 or ifc_i is 1, and is otherwise held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tad_i | input | 1 | Addressed as talker (TADS, TACS or SPAS) |
| lad_i | input | 1 | Addressed as listener (LADS or LACS) |
| atn_n_i | input | 1 | ATN level, 0 means asserted |
| ifc_i | input | 1 | Interface clear pulse |
| dcl_i | input | 1 | Device clear received pulse |
| dcl_ack_i | input | 1 | Device clear serviced acknowledge |
| stb_req_i | input | 1 | Serial poll status-byte request flag |
| stb_wr_i | input | 1 | Status byte written strobe |
| end_rx_i | input | 1 | Received END pulse |
| mode_o | output | 5 | One-hot selected task |
| do_ie_o | output | 1 | Data-out interrupt enable |

## Verification
The hardest case to reach is the stale status-byte request: a write has served it, but the upstream stb_req_i flag is still high and tad_i is still set. In that situation the mode must drop to TALK and must not re-enter SPOLL. The stimulus holds stb_req_i high for several cycles after the write pulse, then lowers and raises it again to show that the request is live once more. A second awkward point is a device-clear acknowledge that lands together with a fresh dcl_i pulse. The directed part of the bench builds it explicitly, and the random phase also reaches it repeatedly with dense pulse rates.

// File: rtl/gpib_arb_pkg.sv
package gpib_arb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_DCLR   = 3'd1,
        ST_SPOLL  = 3'd2,
        ST_TALK   = 3'd3,
        ST_LISTEN = 3'd4
    } arb_state_e;

    localparam int MODE_W = 5;

    localparam int MB_IDLE   = 0;
    localparam int MB_DCLR   = 1;
    localparam int MB_SPOLL  = 2;
    localparam int MB_TALK   = 3;
    localparam int MB_LISTEN = 4;

    function automatic logic [MODE_W-1:0] mode_bit(input int idx);
        logic [MODE_W-1:0] v;
        v = '0;
        v[idx] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/gpib_dcl_latch.sv
module gpib_dcl_latch (
    input  logic clk,
    input  logic rst,
    input  logic dcl_i,
    input  logic dcl_ack_i,
    output logic dcl_live_o
);
    logic pend_q;

    // live this cycle: new pulse, or an older one not being acknowledged
    assign dcl_live_o = dcl_i | (pend_q & ~dcl_ack_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= dcl_live_o;
        end
    end
endmodule

// File: rtl/gpib_spoll_track.sv
module gpib_spoll_track (
    input  logic clk,
    input  logic rst,
    input  logic stb_req_i,
    input  logic stb_wr_i,
    output logic sp_live_o
);
    logic served_q;

    // request counts only until the status byte has been written
    assign sp_live_o = stb_req_i & ~stb_wr_i & ~served_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            served_q <= 1'b0;
        end else begin
            served_q <= stb_req_i & (served_q | stb_wr_i);
        end
    end
endmodule

// File: rtl/gpib_do_irq.sv
module gpib_do_irq (
    input  logic clk,
    input  logic rst,
    input  logic atn_n_i,
    input  logic ifc_i,
    input  logic enter_talk_i,
    output logic do_ie_o
);
    logic ie_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ie_q <= 1'b1;
        end else if (ifc_i || !atn_n_i) begin
            ie_q <= 1'b1;
        end else if (enter_talk_i) begin
            ie_q <= 1'b0;
        end
    end

    assign do_ie_o = ie_q;
endmodule

// File: rtl/gpib_mode_fsm.sv
module gpib_mode_fsm
    import gpib_arb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ifc_i,
    input  logic              dcl_live_i,
    input  logic              sp_live_i,
    input  logic              tacs_i,
    input  logic              lacs_i,
    output logic              enter_talk_o,
    output logic [MODE_W-1:0] mode_o
);
    arb_state_e state_q, state_d;

    // prioritised task choice shared by every state
    function automatic arb_state_e pick(input logic ifc, input logic dcl,
                                        input logic sp, input logic tk,
                                        input logic ls);
        if (ifc)      return ST_IDLE;
        else if (dcl) return ST_DCLR;
        else if (sp)  return ST_SPOLL;
        else if (tk)  return ST_TALK;
        else if (ls)  return ST_LISTEN;
        else          return ST_IDLE;
    endfunction

    always_comb begin
        state_d = pick(ifc_i, dcl_live_i, sp_live_i, tacs_i, lacs_i);
        unique case (state_q)
            ST_IDLE:   ; // leaves on any qualified task
            ST_DCLR:   ; // held while the clear is live, acknowledge releases it
            ST_SPOLL:  ; // status-byte write releases it
            ST_TALK:   ; // ATN assertion removes tacs_i: back to idle (TADS)
            ST_LISTEN: ; // END does not appear here: listening continues
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign enter_talk_o = (state_d == ST_TALK);

    // output decode
    always_comb begin
        unique case (state_q)
            ST_IDLE:   mode_o = mode_bit(MB_IDLE);
            ST_DCLR:   mode_o = mode_bit(MB_DCLR);
            ST_SPOLL:  mode_o = mode_bit(MB_SPOLL);
            ST_TALK:   mode_o = mode_bit(MB_TALK);
            ST_LISTEN: mode_o = mode_bit(MB_LISTEN);
            default:   mode_o = mode_bit(MB_IDLE);
        endcase
    end
endmodule

// File: rtl/gpib_dev_arbiter.sv
module gpib_dev_arbiter
    import gpib_arb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tad_i,
    input  logic              lad_i,
    input  logic              atn_n_i,
    input  logic              ifc_i,
    input  logic              dcl_i,
    input  logic              dcl_ack_i,
    input  logic              stb_req_i,
    input  logic              stb_wr_i,
    input  logic              end_rx_i,
    output logic [MODE_W-1:0] mode_o,
    output logic              do_ie_o
);
    logic dcl_live, sp_live, tacs, lacs, enter_talk;

    // END only marks a message boundary, it never changes the task
    logic unused_end;
    assign unused_end = end_rx_i;

    gpib_dcl_latch u_dcl (
        .clk        (clk),
        .rst        (rst),
        .dcl_i      (dcl_i),
        .dcl_ack_i  (dcl_ack_i),
        .dcl_live_o (dcl_live)
    );

    gpib_spoll_track u_sp (
        .clk       (clk),
        .rst       (rst),
        .stb_req_i (stb_req_i),
        .stb_wr_i  (stb_wr_i),
        .sp_live_o (sp_live)
    );

    // genuine TACS: addressed talker, ATN released, not serially polled
    assign tacs = tad_i & atn_n_i & ~sp_live;
    // listener active while the talker side rests in TIDS
    assign lacs = lad_i & ~tad_i;

    gpib_mode_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .ifc_i        (ifc_i),
        .dcl_live_i   (dcl_live),
        .sp_live_i    (sp_live),
        .tacs_i       (tacs),
        .lacs_i       (lacs),
        .enter_talk_o (enter_talk),
        .mode_o       (mode_o)
    );

    gpib_do_irq u_irq (
        .clk          (clk),
        .rst          (rst),
        .atn_n_i      (atn_n_i),
        .ifc_i        (ifc_i),
        .enter_talk_i (enter_talk),
        .do_ie_o      (do_ie_o)
    );
endmodule

// File: rtl/gpib_dev_arbiter_chk.sv
module gpib_dev_arbiter_chk
    import gpib_arb_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              tad_i,
    input logic              lad_i,
    input logic              atn_n_i,
    input logic              ifc_i,
    input logic              dcl_i,
    input logic              dcl_ack_i,
    input logic              stb_req_i,
    input logic              stb_wr_i,
    input logic              end_rx_i,
    input logic [MODE_W-1:0] mode_o,
    input logic              do_ie_o
);
    a_r2_onehot: assert property (@(posedge clk) disable iff (rst)
        $countones(mode_o) == 1);

    a_r3_talk_qualified: assert property (@(posedge clk) disable iff (rst)
        (tad_i && !atn_n_i) |=> !mode_o[MB_TALK]);

    a_r4_ifc_idle: assert property (@(posedge clk) disable iff (rst)
        ifc_i |=> mode_o[MB_IDLE]);

    a_r5_write_leaves_spoll: assert property (@(posedge clk) disable iff (rst)
        stb_wr_i |=> !mode_o[MB_SPOLL]);

    a_r8_clear_first: assert property (@(posedge clk) disable iff (rst)
        (dcl_i && !ifc_i) |=> mode_o[MB_DCLR]);

    a_r10_mask_on_talk: assert property (@(posedge clk) disable iff (rst)
        $rose(mode_o[MB_TALK]) |-> !do_ie_o);

    a_r10_rearm: assert property (@(posedge clk) disable iff (rst)
        (!atn_n_i || ifc_i) |=> do_ie_o);
endmodule

bind gpib_dev_arbiter gpib_dev_arbiter_chk u_chk (.*);

// File: tb/tb_gpib_dev_arbiter.sv
`timescale 1ns/1ps
module tb_gpib_dev_arbiter;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tad = 0, lad = 0, atn_n = 1, ifc = 0, dcl = 0, ack = 0;
    logic sreq = 0, swr = 0, endp = 0;
    logic [4:0] mode;
    logic       ie;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string tag = "R1";

    // reference state (behavioural)
    int m_pend = 0, m_served = 0, m_ie = 1, m_mode = 0; // m_mode: index of hot bit

    always #10 clk = ~clk;

    gpib_dev_arbiter dut (
        .clk(clk), .rst(rst), .tad_i(tad), .lad_i(lad), .atn_n_i(atn_n),
        .ifc_i(ifc), .dcl_i(dcl), .dcl_ack_i(ack), .stb_req_i(sreq),
        .stb_wr_i(swr), .end_rx_i(endp), .mode_o(mode), .do_ie_o(ie)
    );

    always @(posedge clk) begin
        int dlive, slive, nxt;
        cycles++;
        if (rst) begin
            m_pend = 0; m_served = 0; m_ie = 1; m_mode = 0;
        end else begin
            dlive = (dcl || (m_pend && !ack)) ? 1 : 0;
            slive = (sreq && !swr && !m_served) ? 1 : 0;
            if (ifc) nxt = 0;
            else if (dlive != 0) nxt = 1;
            else if (slive != 0) nxt = 2;
            else if (tad && atn_n) nxt = 3;
            else if (lad && !tad) nxt = 4;
            else nxt = 0;
            if (ifc || !atn_n) m_ie = 1;
            else if (nxt == 3) m_ie = 0;
            m_served = (sreq && (m_served != 0 || swr)) ? 1 : 0;
            m_pend = dlive;
            m_mode = nxt;
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            checks++;
            if (mode !== (5'b1 << m_mode) || ie !== m_ie[0]) begin
                errors++;
                $display("FAIL %s model compare: mode=%b ie=%b expected mode=%b ie=%0d",
                         tag, mode, ie, 5'b1 << m_mode, m_ie);
            end
        end
    end

    task automatic expect_out(input logic [4:0] em, input logic eie, input string rq);
        checks++;
        if (mode !== em || ie !== eie) begin
            errors++;
            $display("FAIL %s directed: mode=%b ie=%b expected mode=%b ie=%b",
                     rq, mode, ie, em, eie);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    localparam logic [4:0] IDLE = 5'b00001, DCLR = 5'b00010, SPOLL = 5'b00100,
                           TALK = 5'b01000, LISTEN = 5'b10000;

    initial begin
        tick(3);
        rst = 0;
        tick(1);
        expect_out(IDLE, 1'b1, "R1");

        tag = "R6"; lad = 1; tick(1);
        expect_out(LISTEN, 1'b1, "R6");
        tag = "R7"; endp = 1; tick(1); endp = 0;
        expect_out(LISTEN, 1'b1, "R7");
        tick(1);
        expect_out(LISTEN, 1'b1, "R7");

        tag = "R3"; lad = 0; tad = 1; atn_n = 0; tick(2);
        expect_out(IDLE, 1'b1, "R3");
        atn_n = 1; tick(1);
        expect_out(TALK, 1'b0, "R10");
        tick(2);
        expect_out(TALK, 1'b0, "R10");

        tag = "R4"; atn_n = 0; tick(1);
        expect_out(IDLE, 1'b1, "R4");
        atn_n = 1; tick(1);
        expect_out(TALK, 1'b0, "R3");
        ifc = 1; tick(1); ifc = 0;
        expect_out(IDLE, 1'b1, "R4");
        tad = 0; tick(1);

        tag = "R5"; tad = 1; sreq = 1; tick(1);
        expect_out(SPOLL, 1'b1, "R5");
        swr = 1; tick(1); swr = 0;
        expect_out(TALK, 1'b0, "R5");
        tick(3);
        expect_out(TALK, 1'b0, "R5");
        sreq = 0; tick(1); sreq = 1; tick(1);
        expect_out(SPOLL, 1'b0, "R5");

        tag = "R8"; lad = 1; tad = 0; dcl = 1; tick(1); dcl = 0;
        expect_out(DCLR, 1'b0, "R8");
        tag = "R9"; tick(2);
        expect_out(DCLR, 1'b0, "R9");
        ack = 1; dcl = 1; tick(1); dcl = 0;
        expect_out(DCLR, 1'b0, "R9");
        tick(1); ack = 0;
        expect_out(SPOLL, 1'b0, "R8");
        sreq = 0; tick(1);
        expect_out(LISTEN, 1'b0, "R8");

        tag = "R2";
        for (int k = 0; k < 3000; k++) begin
            tad   = ($urandom_range(0, 2) != 0);
            lad   = ($urandom_range(0, 1) != 0);
            atn_n = ($urandom_range(0, 4) != 0);
            ifc   = ($urandom_range(0, 30) == 0);
            dcl   = ($urandom_range(0, 15) == 0);
            ack   = ($urandom_range(0, 3) == 0);
            sreq  = ($urandom_range(0, 5) != 0) ? sreq : ~sreq;
            swr   = ($urandom_range(0, 6) == 0);
            endp  = ($urandom_range(0, 4) == 0);
            tick(1);
        end

        tag = "R1"; rst = 1; tick(1); rst = 0;
        tad = 0; lad = 0; atn_n = 1; ifc = 0; dcl = 0; ack = 0;
        sreq = 0; swr = 0; endp = 0;
        tick(1);
        expect_out(IDLE, 1'b1, "R1");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait (cycles > 20000);
        errors++;
        $display("FAIL watchdog: cycles=%0d expected below 20000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule